// File: doc/BRIEF.md
# Memory response beat formatter

This block sits at the receive edge of a memory controller. It takes one finished read or write response at a time and places it on a wide response bus toward the application. Each response holds a tag, a command, a payload size code, a 7-bit error status, a data-invalid flag and up to 128 bytes of payload. The block cuts the payload into 512-bit beats and marks the first and last beat. It keeps every sideband field steady until the response has been fully sent.

The input side uses a valid/ready handshake. `in_ready` is low only while the second beat of a two-beat response is still to go out. A response offered then waits, unchanged, until `in_ready` rises again. The output side has no ready input and cannot be stalled. Each beat is shown for exactly one cycle, so the application must be able to take every beat it is sent. An accepted response shows its first beat in the next cycle. The next response can start in the cycle right after an end-of-packet beat, with no gap.

Top module: `resp_beat_fmt`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_sop` and `out_eop` are low and `in_ready` is high.
- R2: A response accepted on a clock edge (`in_valid` and `in_ready` both high) shows its first beat on the outputs right after that edge, with `out_valid` and `out_sop` high.
- R3: A payload response with size code 0 to 3 takes one beat, with `out_sop` and `out_eop` both high. Size code 4 to 7 takes two beats in consecutive cycles: the first has `out_eop` low and the second has `out_sop` low and `out_eop` high.
- R4: The payload length is (code+1)*16 bytes. Payload byte i (input bits [8i+7:8i]) goes out in beat i/64, at byte i%64 of `out_data`.
- R5: When the last beat is only partly filled, its bytes sit at the low end of `out_data` and all bytes above the payload are driven to zero.
- R6: A response whose command bit 0 is 1 has no payload. It goes out as a single beat with `out_sop` and `out_eop` both high and `out_data` all zero, whatever its size code.
- R7: `out_tag`, `out_cmd`, `out_size`, `out_error` and `out_estat` equal the accepted input values on every beat, and do not change between the beats of one response.
- R8: `out_error` is high exactly when the accepted error status is non-zero or its data-invalid flag is set. `out_estat` passes the 7-bit status through unchanged.
- R9: While a second beat is pending, `in_ready` is low. A response offered during that time is not taken and has no effect on the beat in flight. It is taken in the cycle after the end-of-packet beat.
- R10: Every beat is valid for exactly one cycle. After an end-of-packet beat with no new response accepted, `out_valid` drops in the next cycle.
- R11: A reset during a two-beat response drops the remaining beat. Valid, start and end strobes go low and `in_ready` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A response is offered |
| in_ready | output | 1 | The block can take a response this cycle |
| in_tag | input | 9 | Request tag |
| in_cmd | input | 6 | Response command; bit 0 set means no payload |
| in_size | input | 3 | Payload size code, length (code+1)*16 bytes |
| in_estat | input | 7 | Error status from the memory device |
| in_dinv | input | 1 | Data-invalid flag |
| in_data | input | 1024 | Payload, byte i in bits [8i+7:8i] |
| out_valid | output | 1 | Beat valid |
| out_sop | output | 1 | First beat of a response |
| out_eop | output | 1 | Last beat of a response |
| out_tag | output | 9 | Tag of the current response |
| out_cmd | output | 6 | Command of the current response |
| out_size | output | 3 | Size code of the current response |
| out_error | output | 1 | Response completed with an error |
| out_estat | output | 7 | Error status, passed through |
| out_data | output | 512 | Beat data, unused upper bytes zero |

## Verification
The bench builds the block with its default parameters: a 512-bit bus, 16-byte size steps and a 3-bit size code. With these values all eight size codes are reachable, which covers both one-beat and two-beat responses. They also cover the exactly-64-byte case, where one beat is full, and the 80- and 112-byte cases, where the second beat is partly filled and its upper bytes must be zero. Directed cases cover a response held on the input while a second beat is pending, back-to-back responses, a no-payload command with a non-zero size code, and a reset in the middle of a response.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  localparam int TAG_W   = 9;
  localparam int CMD_W   = 6;
  localparam int ESTAT_W = 7;
  localparam int SIZE_W  = 3;

  // Fields that ride unchanged on every beat of a response
  typedef struct packed {
    logic [TAG_W-1:0]   tag;
    logic [CMD_W-1:0]   cmd;
    logic [SIZE_W-1:0]  size;
    logic               error;
    logic [ESTAT_W-1:0] estat;
  } rbf_side_t;

endpackage

// File: rtl/rbf_len_decode.sv
module rbf_len_decode #(
  parameter int SIZE_W     = 3,
  parameter int STEP_BYTES = 16,
  parameter int BUS_BYTES  = 64,
  localparam int MAX_BYTES = (2 ** SIZE_W) * STEP_BYTES,
  localparam int TOT_W     = $clog2(MAX_BYTES + 1) + 1,
  localparam int CNT_W     = $clog2(BUS_BYTES + 1)
) (
  input  logic [SIZE_W-1:0] size_i,
  input  logic              no_payload_i,
  output logic [CNT_W-1:0]  lo_cnt_o,
  output logic [CNT_W-1:0]  hi_cnt_o,
  output logic              two_beat_o
);

  logic [TOT_W-1:0] total;

  always_comb begin
    total = (TOT_W'(size_i) + TOT_W'(1)) * TOT_W'(STEP_BYTES);
    if (no_payload_i) begin
      lo_cnt_o = '0;
      hi_cnt_o = '0;
    end else if (total > TOT_W'(BUS_BYTES)) begin
      lo_cnt_o = CNT_W'(BUS_BYTES);
      hi_cnt_o = CNT_W'(total - TOT_W'(BUS_BYTES));
    end else begin
      lo_cnt_o = CNT_W'(total);
      hi_cnt_o = '0;
    end
    two_beat_o = (hi_cnt_o != '0);
  end

endmodule

// File: rtl/rbf_byte_mask.sv
module rbf_byte_mask #(
  parameter int BYTES  = 64,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [BYTES*8-1:0] data_i,
  output logic [BYTES*8-1:0] data_o
);

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign data_o[b*8 +: 8] = (b < int'(cnt_i)) ? data_i[b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/rbf_beat_seq.sv
module rbf_beat_seq
  import rbf_pkg::*;
#(
  parameter int BUS_W = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             two_beat_i,
  input  rbf_side_t        side_i,
  input  logic [BUS_W-1:0] lo_i,
  input  logic [BUS_W-1:0] hi_i,
  output logic             ready_o,
  output logic             valid_o,
  output logic             sop_o,
  output logic             eop_o,
  output rbf_side_t        side_o,
  output logic [BUS_W-1:0] data_o
);

  logic             pend_q;
  logic [BUS_W-1:0] hi_q;

  assign ready_o = !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      pend_q  <= 1'b0;
    end else if (pend_q) begin
      valid_o <= 1'b1;
      sop_o   <= 1'b0;
      eop_o   <= 1'b1;
      data_o  <= hi_q;
      pend_q  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      sop_o   <= 1'b1;
      eop_o   <= !two_beat_i;
      pend_q  <= two_beat_i;
      side_o  <= side_i;
      data_o  <= lo_i;
      hi_q    <= hi_i;
    end else begin
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
    end
  end

endmodule

// File: rtl/resp_beat_fmt.sv
module resp_beat_fmt
  import rbf_pkg::*;
#(
  parameter int BUS_W      = 512,
  parameter int STEP_BYTES = 16,
  localparam int BUS_BYTES = BUS_W / 8,
  localparam int PAY_W     = 2 * BUS_W,
  localparam int CNT_W     = $clog2(BUS_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [CMD_W-1:0]   in_cmd,
  input  logic [SIZE_W-1:0]  in_size,
  input  logic [ESTAT_W-1:0] in_estat,
  input  logic               in_dinv,
  input  logic [PAY_W-1:0]   in_data,
  output logic               out_valid,
  output logic               out_sop,
  output logic               out_eop,
  output logic [TAG_W-1:0]   out_tag,
  output logic [CMD_W-1:0]   out_cmd,
  output logic [SIZE_W-1:0]  out_size,
  output logic               out_error,
  output logic [ESTAT_W-1:0] out_estat,
  output logic [BUS_W-1:0]   out_data
);

  logic [CNT_W-1:0] lo_cnt, hi_cnt;
  logic             two_beat, load;
  logic [BUS_W-1:0] lo_beat, hi_beat;
  rbf_side_t        side_in, side_out;

  rbf_len_decode #(
    .SIZE_W(SIZE_W), .STEP_BYTES(STEP_BYTES), .BUS_BYTES(BUS_BYTES)
  ) u_len (
    .size_i(in_size), .no_payload_i(in_cmd[0]),
    .lo_cnt_o(lo_cnt), .hi_cnt_o(hi_cnt), .two_beat_o(two_beat)
  );

  rbf_byte_mask #(.BYTES(BUS_BYTES)) u_mask_lo (
    .cnt_i(lo_cnt), .data_i(in_data[BUS_W-1:0]), .data_o(lo_beat)
  );

  rbf_byte_mask #(.BYTES(BUS_BYTES)) u_mask_hi (
    .cnt_i(hi_cnt), .data_i(in_data[PAY_W-1:BUS_W]), .data_o(hi_beat)
  );

  always_comb begin
    side_in.tag   = in_tag;
    side_in.cmd   = in_cmd;
    side_in.size  = in_size;
    side_in.error = (in_estat != '0) || in_dinv;
    side_in.estat = in_estat;
  end

  assign load = in_valid && in_ready;

  rbf_beat_seq #(.BUS_W(BUS_W)) u_seq (
    .clk(clk), .rst(rst), .load_i(load), .two_beat_i(two_beat),
    .side_i(side_in), .lo_i(lo_beat), .hi_i(hi_beat),
    .ready_o(in_ready), .valid_o(out_valid), .sop_o(out_sop),
    .eop_o(out_eop), .side_o(side_out), .data_o(out_data)
  );

  assign out_tag   = side_out.tag;
  assign out_cmd   = side_out.cmd;
  assign out_size  = side_out.size;
  assign out_error = side_out.error;
  assign out_estat = side_out.estat;

endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
  parameter int BUS_W   = 512,
  parameter int TAG_W   = 9,
  parameter int CMD_W   = 6,
  parameter int SIZE_W  = 3,
  parameter int ESTAT_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic [CMD_W-1:0]   in_cmd,
  input logic [ESTAT_W-1:0] in_estat,
  input logic               in_dinv,
  input logic               out_valid,
  input logic               out_sop,
  input logic               out_eop,
  input logic [TAG_W-1:0]   out_tag,
  input logic [CMD_W-1:0]   out_cmd,
  input logic [SIZE_W-1:0]  out_size,
  input logic               out_error,
  input logic [ESTAT_W-1:0] out_estat,
  input logic [BUS_W-1:0]   out_data
);

  assert_strobes_need_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (out_sop || out_eop) |-> out_valid);

  assert_accept_starts_packet_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_sop));

  assert_second_beat_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |=> (out_valid && !out_sop && out_eop));

  assert_sideband_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |=> ($stable(out_tag) && $stable(out_cmd) &&
      $stable(out_size) && $stable(out_error) && $stable(out_estat)));

  assert_no_take_mid_packet_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |-> !in_ready);

  assert_error_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && ((in_estat != '0) || in_dinv)) |=> out_error);

  assert_no_payload_single_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_cmd[0]) |=> (out_sop && out_eop && (out_data == '0)));

endmodule

bind resp_beat_fmt rbf_checker #(
  .BUS_W(BUS_W), .TAG_W(rbf_pkg::TAG_W), .CMD_W(rbf_pkg::CMD_W),
  .SIZE_W(rbf_pkg::SIZE_W), .ESTAT_W(rbf_pkg::ESTAT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_cmd(in_cmd), .in_estat(in_estat), .in_dinv(in_dinv),
  .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
  .out_tag(out_tag), .out_cmd(out_cmd), .out_size(out_size),
  .out_error(out_error), .out_estat(out_estat), .out_data(out_data)
);

// File: tb/resp_beat_fmt_tb.sv
module resp_beat_fmt_tb;

  localparam int BUS_W = 512;
  localparam int PAY_W = 2 * BUS_W;

  typedef struct packed {
    logic [8:0] tag;
    logic [5:0] cmd;
    logic [2:0] size;
    logic [6:0] estat;
    logic       dinv;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{9'h001, 6'h38, 3'd0, 7'h00, 1'b0, 8'h11},
    '{9'h1FF, 6'h38, 3'd3, 7'h00, 1'b0, 8'h22},
    '{9'h0A5, 6'h3A, 3'd4, 7'h05, 1'b0, 8'h33},
    '{9'h123, 6'h38, 3'd6, 7'h00, 1'b1, 8'h44},
    '{9'h0F0, 6'h3E, 3'd7, 7'h00, 1'b0, 8'h55},
    '{9'h055, 6'h39, 3'd5, 7'h00, 1'b0, 8'h66},
    '{9'h100, 6'h38, 3'd1, 7'h7F, 1'b0, 8'h77},
    '{9'h0C3, 6'h3C, 3'd2, 7'h00, 1'b0, 8'h88}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [8:0]       in_tag = '0;
  logic [5:0]       in_cmd = '0;
  logic [2:0]       in_size = '0;
  logic [6:0]       in_estat = '0;
  logic             in_dinv = 1'b0;
  logic [PAY_W-1:0] in_data = '0;
  logic             out_valid, out_sop, out_eop, out_error;
  logic [8:0]       out_tag;
  logic [5:0]       out_cmd;
  logic [2:0]       out_size;
  logic [6:0]       out_estat;
  logic [BUS_W-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  resp_beat_fmt u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_cmd(in_cmd), .in_size(in_size),
    .in_estat(in_estat), .in_dinv(in_dinv), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_tag(out_tag), .out_cmd(out_cmd), .out_size(out_size),
    .out_error(out_error), .out_estat(out_estat), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [BUS_W-1:0] act,
                     input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [PAY_W-1:0] mk_payload(input logic [7:0] seed);
    logic [PAY_W-1:0] p;
    for (int i = 0; i < PAY_W / 8; i++) p[i*8 +: 8] = 8'(seed + 8'(i * 37) + 8'd1);
    return p;
  endfunction

  function automatic logic [BUS_W-1:0] exp_beat(input logic [PAY_W-1:0] p,
      input int k, input int total, input logic nopay);
    logic [BUS_W-1:0] d = '0;
    for (int j = 0; j < BUS_W / 8; j++) begin
      if (!nopay && (k * 64 + j) < total) d[j*8 +: 8] = p[(k*64+j)*8 +: 8];
    end
    return d;
  endfunction

  task automatic drive(input vec_t v);
    in_valid = 1'b1;
    in_tag   = v.tag;
    in_cmd   = v.cmd;
    in_size  = v.size;
    in_estat = v.estat;
    in_dinv  = v.dinv;
    in_data  = mk_payload(v.seed);
  endtask

  task automatic chk_side(input vec_t v);
    chk("R7 tag", BUS_W'(out_tag), BUS_W'(v.tag));
    chk("R7 cmd", BUS_W'(out_cmd), BUS_W'(v.cmd));
    chk("R7 size", BUS_W'(out_size), BUS_W'(v.size));
    chk("R8 error", BUS_W'(out_error), BUS_W'((v.estat != 0) || v.dinv));
    chk("R8 estat", BUS_W'(out_estat), BUS_W'(v.estat));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", BUS_W'(out_valid), '0);
    chk("R1 sop", BUS_W'(out_sop), '0);
    chk("R1 eop", BUS_W'(out_eop), '0);
    chk("R1 ready", BUS_W'(in_ready), BUS_W'(1));
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int n = 0; n < 8; n++) begin
      vec_t v = VECS[n];
      logic nopay = v.cmd[0];
      int total = (int'(v.size) + 1) * 16;
      int beats = nopay ? 1 : (total > 64 ? 2 : 1);
      logic [PAY_W-1:0] p = mk_payload(v.seed);
      @(negedge clk);
      drive(v);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 valid", BUS_W'(out_valid), BUS_W'(1));
      chk("R2 sop", BUS_W'(out_sop), BUS_W'(1));
      chk("R3 eop first", BUS_W'(out_eop), BUS_W'(beats == 1));
      chk(nopay ? "R6 zero data" : "R4 R5 beat0", out_data, exp_beat(p, 0, total, nopay));
      chk_side(v);
      if (beats == 2) begin
        @(posedge clk);
        @(negedge clk);
        chk("R3 valid second", BUS_W'(out_valid), BUS_W'(1));
        chk("R3 sop second", BUS_W'(out_sop), '0);
        chk("R3 eop second", BUS_W'(out_eop), BUS_W'(1));
        chk("R4 R5 beat1", out_data, exp_beat(p, 1, total, 1'b0));
        chk_side(v);
      end
      @(posedge clk);
      @(negedge clk);
      chk("R10 idle valid", BUS_W'(out_valid), '0);
    end

    // R9: response offered while a second beat is pending, then back-to-back
    begin
      vec_t a = VECS[4];
      vec_t b = VECS[7];
      @(negedge clk);
      drive(a);
      @(posedge clk);
      @(negedge clk);
      chk("R9 ready low", BUS_W'(in_ready), '0);
      drive(b);
      @(posedge clk);
      @(negedge clk);
      chk("R9 second beat kept", out_data, exp_beat(mk_payload(a.seed), 1, 128, 1'b0));
      chk("R9 tag kept", BUS_W'(out_tag), BUS_W'(a.tag));
      chk("R9 eop", BUS_W'(out_eop), BUS_W'(1));
      chk("R9 ready high", BUS_W'(in_ready), BUS_W'(1));
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 next sop", BUS_W'(out_sop), BUS_W'(1));
      chk("R9 next tag", BUS_W'(out_tag), BUS_W'(b.tag));
      chk("R9 next data", out_data, exp_beat(mk_payload(b.seed), 0, 48, 1'b0));
      @(posedge clk);
      @(negedge clk);
      chk("R10 valid drops", BUS_W'(out_valid), '0);
    end

    // R11: reset between the two beats drops the rest
    @(negedge clk);
    drive(VECS[3]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 valid", BUS_W'(out_valid), '0);
    chk("R11 sop", BUS_W'(out_sop), '0);
    chk("R11 eop", BUS_W'(out_eop), '0);
    chk("R11 ready", BUS_W'(in_ready), BUS_W'(1));
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 stays idle", BUS_W'(out_valid), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule